// File: doc/BRIEF.md
# SPI serial EEPROM slave controller

This block is the serial front end of a 512-byte nonvolatile memory. It answers an SPI master on four wires: serial clock, serial data in, an active-low select, and serial data out with a separate output-enable for an external tri-state pad. The three inputs are oversampled in the system clock domain, so all logic runs on one clock and the serial clock must be much slower than the system clock.

A transaction begins with an 8-bit opcode. Array commands carry the ninth address bit inside the opcode, and the low eight address bits follow in a second byte. Read data then streams out with an automatic address increment. Write data goes into a 16-entry page staging buffer, and the memory is updated only when the select is released on a byte boundary. A commit starts a fixed busy period. During that period the staged bytes are copied into a synchronous RAM model, and every command except the status read is ignored. A write-enable latch guards both array and status writes.

Top module: `spi_nvm_slave`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges and output data changes after falling edges. Transactions work with the clock idling low and with the clock idling high.
- R2: Bits travel MSB first. Opcodes are: array read `0000_A011` and array write `0000_A010`, where bit 3 is address bit 8; set write-enable `0x06`; clear write-enable `0x04`; status read `0x05`; status write `0x01`. Any other byte is an unknown opcode.
- R3: A read sends the low address byte after the opcode, and data bytes then follow on every further 8 clocks. The address advances by one per byte and wraps from 0x1FF to 0x000.
- R4: Set and clear write-enable take effect only when select rises after exactly 8 bits. The latch is visible as status bit 1.
- R5: A write stores data bytes at consecutive addresses whose low 4 bits wrap inside the 16-byte page. A later byte at the same offset replaces an earlier one.
- R6: A write reaches memory only if the latch is set and select rises after a whole number (at least one) of data bytes. Otherwise nothing changes, no busy period starts and the latch keeps its value.
- R7: A committed write or status write sets status bit 0 (busy) for BUSY_CYCLES system cycles and clears the latch. While busy, every opcode except status read is ignored, so array reads drive nothing.
- R8: A status write takes one data byte. Its bits 3:2 become status bits 3:2 only if the latch is set and select rises right after that byte.
- R9: The output enable is low while select is high, during opcode and address bits, and for the whole of an unknown or ignored opcode.
- R10: The status byte is {4'b0000, protect[1:0], latch, busy}. It repeats on every further byte while the clock continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the master |
| siIn | input | 1 | Serial data from the master |
| csNIn | input | 1 | Active-low select |
| soOut | output | 1 | Serial data to the master |
| soOe | output | 1 | Output enable for the serial data pad |

## Verification
Serial input and clock pass through SYNC_STAGES flops plus one edge register, so each output bit settles about three system cycles after a falling serial-clock edge. The bench holds every half period for six system cycles and samples the output just before the next rising edge. A commit takes effect about three cycles after select rises. The busy flag is read inside the first half of the busy window, and it is checked low only after a wait of BUSY_CYCLES plus a margin. Memory contents are compared only after that wait.

// File: rtl/spi_nvm_pkg.sv
package spi_nvm_pkg;
  localparam int ADDR_W  = 9;
  localparam int PAGE_AW = 4;

  typedef enum logic [2:0] {
    CMD_IDLE, CMD_READ, CMD_WRITE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_SKIP
  } cmd_e;

  typedef struct packed {
    logic               captureHi;
    logic               captureLow;
    logic               clearPage;
    logic               storeData;
    logic               storeStat;
    logic               loadOut;
    logic               loadStatus;
    logic               shiftOut;
    logic               commitWr;
    logic [PAGE_AW-1:0] commitIdx;
    logic               setProt;
  } strobe_t;
endpackage

// File: rtl/spi_nvm_sync.sv
module spi_nvm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic siIn,
  input  logic csNIn,
  output logic sckRise,
  output logic sckFall,
  output logic siBit,
  output logic csActive,
  output logic csStart,
  output logic csEnd
);
  logic [STAGES-1:0][2:0] chain;
  logic sckPrev, actPrev, sckNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain   <= {STAGES{3'b100}};
      sckPrev <= 1'b0;
      actPrev <= 1'b0;
    end else begin
      chain[0] <= {csNIn, sckIn, siIn};
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      sckPrev <= sckNow;
      actPrev <= csActive;
    end
  end

  assign sckNow   = chain[STAGES-1][1];
  assign siBit    = chain[STAGES-1][0];
  assign csActive = ~chain[STAGES-1][2];
  assign sckRise  = sckNow & ~sckPrev;
  assign sckFall  = ~sckNow & sckPrev;
  assign csStart  = csActive & ~actPrev;
  assign csEnd    = ~csActive & actPrev;
endmodule

// File: rtl/spi_nvm_ctrl.sv
module spi_nvm_ctrl
  import spi_nvm_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csActive,
  input  logic       csStart,
  input  logic       csEnd,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic [7:0] inByte,
  output strobe_t    stb,
  output logic       soOe,
  output logic       wip,
  output logic       wel
);
  localparam int CNT_W    = $clog2(BUSY_CYCLES + 1);
  localparam int PAGE_LEN = 1 << PAGE_AW;

  cmd_e cmd, decoded;
  logic [2:0] bitCnt;
  logic [1:0] byteCnt;
  logic outPhase, busy, pageCommit, byteDone, aligned, doWrite, doStat, startOut;
  logic [CNT_W-1:0] busyCnt;

  always_comb begin
    decoded = CMD_SKIP;
    if (inByte[7:4] == 4'h0) begin
      if (inByte[2:0] == 3'b011)      decoded = CMD_READ;
      else if (inByte[2:0] == 3'b010) decoded = CMD_WRITE;
      else if (inByte == 8'h06)       decoded = CMD_WREN;
      else if (inByte == 8'h04)       decoded = CMD_WRDI;
      else if (inByte == 8'h05)       decoded = CMD_RDSR;
      else if (inByte == 8'h01)       decoded = CMD_WRSR;
    end
    if (busy && decoded != CMD_RDSR) decoded = CMD_SKIP;
  end

  assign byteDone = csActive && sckRise && bitCnt == 3'd7;
  assign aligned  = bitCnt == 3'd0;
  assign doWrite  = csEnd && cmd == CMD_WRITE && wel && byteCnt == 2'd3 && aligned;
  assign doStat   = csEnd && cmd == CMD_WRSR && wel && byteCnt == 2'd2 && aligned;
  assign startOut = csActive && sckFall && aligned &&
                    ((cmd == CMD_READ && byteCnt >= 2'd2) || (cmd == CMD_RDSR && byteCnt >= 2'd1));

  always_comb begin
    stb            = '0;
    stb.captureHi  = byteDone && byteCnt == 2'd0 && (decoded == CMD_READ || decoded == CMD_WRITE);
    stb.clearPage  = byteDone && byteCnt == 2'd0 && decoded == CMD_WRITE;
    stb.captureLow = byteDone && byteCnt == 2'd1 && (cmd == CMD_READ || cmd == CMD_WRITE);
    stb.storeData  = byteDone && byteCnt >= 2'd2 && cmd == CMD_WRITE;
    stb.storeStat  = byteDone && byteCnt == 2'd1 && cmd == CMD_WRSR;
    stb.loadOut    = startOut && cmd == CMD_READ;
    stb.loadStatus = startOut && cmd == CMD_RDSR;
    stb.shiftOut   = csActive && sckFall && outPhase && !startOut;
    stb.commitWr   = busy && pageCommit && busyCnt < CNT_W'(PAGE_LEN);
    stb.commitIdx  = busyCnt[PAGE_AW-1:0];
    stb.setProt    = doStat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmd <= CMD_IDLE; bitCnt <= '0; byteCnt <= '0; outPhase <= 1'b0;
    end else if (csStart) begin
      cmd <= CMD_IDLE; bitCnt <= '0; byteCnt <= '0; outPhase <= 1'b0;
    end else if (csEnd) begin
      cmd <= CMD_IDLE; outPhase <= 1'b0;
    end else if (csActive) begin
      if (sckRise) begin
        bitCnt <= bitCnt + 3'd1;
        if (bitCnt == 3'd7 && byteCnt != 2'd3) byteCnt <= byteCnt + 2'd1;
        if (bitCnt == 3'd7 && byteCnt == 2'd0) cmd <= decoded;
      end
      if (startOut) outPhase <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0; busy <= 1'b0; pageCommit <= 1'b0; busyCnt <= '0;
    end else begin
      if (csEnd && cmd == CMD_WREN && byteCnt == 2'd1 && aligned) wel <= 1'b1;
      else if ((csEnd && cmd == CMD_WRDI && byteCnt == 2'd1 && aligned) || doWrite || doStat)
        wel <= 1'b0;
      if (doWrite || doStat) begin
        busy <= 1'b1; busyCnt <= '0; pageCommit <= doWrite;
      end else if (busy) begin
        if (busyCnt == CNT_W'(BUSY_CYCLES - 1)) busy <= 1'b0;
        busyCnt <= busyCnt + 1'b1;
      end
    end
  end

  assign soOe = csActive && outPhase;
  assign wip  = busy;

  AST_WEL_DROPS_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !wel); // R7
  AST_NO_ARRAY_READ_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.loadOut); // R7
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> busyCnt < CNT_W'(BUSY_CYCLES)); // R7
  AST_OE_ONLY_OUTPUT_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    soOe |-> (cmd == CMD_READ || cmd == CMD_RDSR)); // R9
  AST_OE_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    csEnd |=> !soOe); // R9
endmodule

// File: rtl/spi_nvm_dp.sv
module spi_nvm_dp
  import spi_nvm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       csActive,
  input  logic       siBit,
  input  strobe_t    stb,
  input  logic       wel,
  input  logic       wip,
  output logic [7:0] inByte,
  output logic       soBit
);
  localparam int DEPTH    = 1 << ADDR_W;
  localparam int PAGE_LEN = 1 << PAGE_AW;

  logic [6:0] shiftIn;
  logic [ADDR_W-1:0] addr;
  logic [7:0] pageBuf [PAGE_LEN];
  logic [PAGE_LEN-1:0] pageVal;
  logic [7:0] mem [DEPTH];
  logic [7:0] rdData, outShift, statusByte;
  logic [1:0] prot, protPend;

  assign inByte     = {shiftIn, siBit};
  assign statusByte = {4'b0000, prot, wel, wip};
  assign soBit      = outShift[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftIn <= '0; addr <= '0; outShift <= '0; prot <= '0; protPend <= '0; pageVal <= '0;
    end else begin
      if (csActive && sckRise) shiftIn <= inByte[6:0];
      if (stb.captureHi)       addr[ADDR_W-1] <= inByte[3];
      else if (stb.captureLow) addr[7:0] <= inByte;
      else if (stb.loadOut)    addr <= addr + 1'b1;
      else if (stb.storeData)  addr[PAGE_AW-1:0] <= addr[PAGE_AW-1:0] + 1'b1;
      if (stb.clearPage)       pageVal <= '0;
      else if (stb.storeData)  pageVal[addr[PAGE_AW-1:0]] <= 1'b1;
      if (stb.loadOut)         outShift <= rdData;
      else if (stb.loadStatus) outShift <= statusByte;
      else if (stb.shiftOut)   outShift <= {outShift[6:0], 1'b0};
      if (stb.storeStat)       protPend <= inByte[3:2];
      if (stb.setProt)         prot <= protPend;
    end
  end

  for (genvar g = 0; g < PAGE_LEN; g++) begin : gPage
    always_ff @(posedge clk) begin
      if (stb.storeData && addr[PAGE_AW-1:0] == PAGE_AW'(g)) pageBuf[g] <= inByte;
    end
  end

  always_ff @(posedge clk) begin
    rdData <= mem[addr];
    if (stb.commitWr && pageVal[stb.commitIdx])
      mem[{addr[ADDR_W-1:PAGE_AW], stb.commitIdx}] <= pageBuf[stb.commitIdx];
  end

  AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    stb.storeData |=> addr[ADDR_W-1:PAGE_AW] == $past(addr[ADDR_W-1:PAGE_AW])); // R5
  AST_READ_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadOut |=> addr == $past(addr) + 1'b1); // R3
  AST_SHIFT_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (stb.shiftOut || stb.loadOut || stb.loadStatus) |-> csActive); // R9
endmodule

// File: rtl/spi_nvm_slave.sv
module spi_nvm_slave
  import spi_nvm_pkg::*;
#(
  parameter int BUSY_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic siIn,
  input  logic csNIn,
  output logic soOut,
  output logic soOe
);
  logic sckRise, sckFall, siBit, csActive, csStart, csEnd, wip, wel;
  logic [7:0] inByte;
  strobe_t stb;

  spi_nvm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .csNIn(csNIn),
    .sckRise(sckRise), .sckFall(sckFall), .siBit(siBit),
    .csActive(csActive), .csStart(csStart), .csEnd(csEnd));

  spi_nvm_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .csStart(csStart), .csEnd(csEnd),
    .sckRise(sckRise), .sckFall(sckFall), .inByte(inByte),
    .stb(stb), .soOe(soOe), .wip(wip), .wel(wel));

  spi_nvm_dp u_dp (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .csActive(csActive), .siBit(siBit),
    .stb(stb), .wel(wel), .wip(wip), .inByte(inByte), .soBit(soOut));
endmodule

// File: tb/spi_nvm_slave_tb.sv
module spi_nvm_slave_tb;
  localparam int BUSY = 400;
  localparam int HALF = 6;

  logic clk = 1'b0, rstN = 1'b0, sckIn = 1'b0, siIn = 1'b0, csNIn = 1'b1;
  logic soOut, soOe;
  int nChecks = 0, nFails = 0;
  logic [7:0] txBuf [64];
  logic [7:0] rxBuf [64];
  logic oeAll [64];
  logic oeAny [64];
  logic [7:0] model [512];
  bit known [512];
  logic [7:0] st;

  always #2 clk = ~clk;

  spi_nvm_slave #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .csNIn(csNIn),
    .soOut(soOut), .soOe(soOe));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] opRd(input logic [8:0] a);
    return {4'b0000, a[8], 3'b011};
  endfunction
  function automatic logic [7:0] opWr(input logic [8:0] a);
    return {4'b0000, a[8], 3'b010};
  endfunction

  task automatic spiRun(input int nBytes, input int extraBits, input bit mode3);
    int total;
    total = nBytes + ((extraBits > 0) ? 1 : 0);
    sckIn = mode3; tick(8);
    csNIn = 1'b0; tick(HALF);
    for (int b = 0; b < total; b++) begin
      int nb;
      nb = (b < nBytes) ? 8 : extraBits;
      rxBuf[b] = 8'h00; oeAll[b] = 1'b1; oeAny[b] = 1'b0;
      for (int k = 7; k >= 8 - nb; k--) begin
        sckIn = 1'b0; siIn = txBuf[b][k]; tick(HALF);
        rxBuf[b][k] = soOut; oeAll[b] = oeAll[b] & soOe; oeAny[b] = oeAny[b] | soOe;
        sckIn = 1'b1; tick(HALF);
      end
    end
    if (!mode3) begin sckIn = 1'b0; tick(HALF); end
    csNIn = 1'b1; tick(8);
  endtask

  task automatic cmd1(input logic [7:0] op, input bit m3);
    txBuf[0] = op; spiRun(1, 0, m3);
  endtask

  task automatic readStatus(input bit m3, output logic [7:0] s);
    txBuf[0] = 8'h05; txBuf[1] = 8'h00; txBuf[2] = 8'h00;
    spiRun(3, 0, m3);
    chk(oeAll[1] && !oeAny[0], "R10 status drive", oeAll[1], 1);
    s = rxBuf[1];
  endtask

  task automatic expectStatus(input logic [7:0] exp, input string req, input bit m3);
    logic [7:0] s;
    readStatus(m3, s);
    chk(s == exp, req, s, exp);
  endtask

  task automatic writeData(input logic [8:0] a, input int n, input bit m3, input bit commit);
    txBuf[0] = opWr(a); txBuf[1] = a[7:0];
    for (int i = 0; i < n; i++) txBuf[2+i] = 8'($urandom);
    spiRun(n + 2, 0, m3);
    for (int i = 0; i < 2 + n; i++) chk(!oeAny[i], "R9 write no drive", oeAny[i], 0);
    if (commit)
      for (int i = 0; i < n; i++) begin
        logic [8:0] idx;
        idx = {a[8:4], 4'(a[3:0] + i)};
        model[idx] = txBuf[2+i]; known[idx] = 1'b1;
      end
  endtask

  task automatic readCheck(input logic [8:0] a, input int n, input bit m3, input string req);
    txBuf[0] = opRd(a); txBuf[1] = a[7:0];
    for (int i = 0; i < n; i++) txBuf[2+i] = 8'($urandom);
    spiRun(n + 2, 0, m3);
    chk(!oeAny[0] && !oeAny[1], "R9 read header", oeAny[1], 0);
    for (int i = 0; i < n; i++) begin
      logic [8:0] idx;
      idx = 9'(a + i);
      chk(oeAll[2+i], req, oeAll[2+i], 1);
      if (known[idx]) chk(rxBuf[2+i] == model[idx], req, rxBuf[2+i], model[idx]);
    end
  endtask

  task automatic waitIdle();
    tick(BUSY + 40);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 512; i++) known[i] = 1'b0;
    tick(5); rstN = 1'b1; tick(5);
    chk(soOe == 1'b0, "R9 reset oe", soOe, 0);
    expectStatus(8'h00, "R10 reset status", 1'b0);

    // R4 write-enable latch
    cmd1(8'h06, 1'b0); expectStatus(8'h02, "R4 set latch", 1'b0);
    cmd1(8'h04, 1'b1); expectStatus(8'h00, "R4 clear latch", 1'b1);
    txBuf[0] = 8'h06; spiRun(0, 7, 1'b0); expectStatus(8'h00, "R4 short enable", 1'b0);
    txBuf[0] = 8'h06; txBuf[1] = 8'h00; spiRun(1, 1, 1'b0); expectStatus(8'h00, "R4 long enable", 1'b0);

    // R7 page write, busy flag
    cmd1(8'h06, 1'b0); writeData(9'h000, 16, 1'b0, 1'b1);
    expectStatus(8'h01, "R7 busy after commit", 1'b0);
    waitIdle(); expectStatus(8'h00, "R7 busy ends", 1'b0);
    readCheck(9'h000, 16, 1'b0, "R3 read page 0 mode0");

    // R2 A8 in opcode, R3 wrap, R1 idle-high clock
    cmd1(8'h06, 1'b1); writeData(9'h1F0, 16, 1'b1, 1'b1); waitIdle();
    readCheck(9'h1FE, 4, 1'b1, "R3 wrap 1FF to 000");
    readCheck(9'h1F0, 3, 1'b1, "R2 high address bit");
    readCheck(9'h000, 3, 1'b1, "R1 idle-high read");

    // R5 page wrap and overwrite
    cmd1(8'h06, 1'b0); writeData(9'h02E, 5, 1'b0, 1'b1); waitIdle();
    readCheck(9'h020, 16, 1'b0, "R5 page wrap");
    cmd1(8'h06, 1'b0); writeData(9'h040, 18, 1'b0, 1'b1); waitIdle();
    readCheck(9'h040, 16, 1'b0, "R5 overwrite");

    // R6 no latch, misaligned release
    writeData(9'h000, 3, 1'b0, 1'b0);
    expectStatus(8'h00, "R6 no latch no busy", 1'b0);
    readCheck(9'h000, 4, 1'b0, "R6 no latch no change");
    cmd1(8'h06, 1'b0);
    txBuf[0] = opWr(9'h000); txBuf[1] = 8'h00; txBuf[2] = 8'hA5; txBuf[3] = 8'h5A; txBuf[4] = 8'hFF;
    spiRun(4, 3, 1'b0);
    expectStatus(8'h02, "R6 discard keeps latch", 1'b0);
    readCheck(9'h000, 4, 1'b0, "R6 discard no change");
    cmd1(8'h04, 1'b0);

    // R7 commands ignored while busy
    cmd1(8'h06, 1'b0); writeData(9'h060, 4, 1'b0, 1'b1);
    cmd1(8'h06, 1'b0);
    txBuf[0] = opRd(9'h000); txBuf[1] = 8'h00; txBuf[2] = 8'h00;
    spiRun(3, 0, 1'b0);
    chk(!oeAny[2], "R7 read blocked while busy", oeAny[2], 0);
    waitIdle(); expectStatus(8'h00, "R7 enable ignored while busy", 1'b0);
    readCheck(9'h060, 4, 1'b0, "R7 commit completes");

    // R9 unknown opcodes, R2 strict upper nibble
    txBuf[0] = 8'h07; txBuf[1] = 8'h00; txBuf[2] = 8'h00; spiRun(3, 0, 1'b0);
    chk(!oeAny[0] && !oeAny[1] && !oeAny[2], "R9 unknown opcode", oeAny[2], 0);
    txBuf[0] = 8'h13; spiRun(3, 0, 1'b1);
    chk(!oeAny[2], "R2 upper nibble must be zero", oeAny[2], 0);

    // R10 repetition
    txBuf[0] = 8'h05; txBuf[1] = 8'h00; txBuf[2] = 8'h00; txBuf[3] = 8'h00; spiRun(4, 0, 1'b1);
    chk(rxBuf[3] == rxBuf[1] && rxBuf[2] == rxBuf[1], "R10 status repeats", rxBuf[3], rxBuf[1]);

    // R1 R3 R5 random traffic
    for (int t = 0; t < 18; t++) begin
      logic [8:0] a;
      bit m3;
      a = 9'($urandom); m3 = 1'($urandom);
      cmd1(8'h06, m3); writeData(a, 1 + int'($urandom % 20), m3, 1'b1); waitIdle();
    end
    for (int t = 0; t < 18; t++)
      readCheck(9'($urandom), 1 + int'($urandom % 16), 1'($urandom), "R1 R3 random read");

    // R8 status write
    txBuf[0] = 8'h01; txBuf[1] = 8'hFF; spiRun(2, 0, 1'b0); waitIdle();
    expectStatus(8'h00, "R8 no latch ignored", 1'b0);
    cmd1(8'h06, 1'b0); txBuf[0] = 8'h01; txBuf[1] = 8'hFF; spiRun(2, 0, 1'b0);
    expectStatus(8'h0D, "R8 commit busy", 1'b0);
    waitIdle(); expectStatus(8'h0C, "R8 protect bits stored", 1'b1);
    cmd1(8'h06, 1'b0); txBuf[0] = 8'h01; txBuf[1] = 8'h00; txBuf[2] = 8'h00; spiRun(3, 0, 1'b0);
    waitIdle(); expectStatus(8'h0E, "R8 two data bytes rejected", 1'b0);

    summary();
    $finish;
  end
endmodule